// File: doc/BRIEF.md
# Supervisor Reset Release Sequencer

This block produces the active-low system reset for a chip domain from three fault sources. The first is a digitized undervoltage flag. The second is a synchronous lockout flag that reports the supply is below its minimum. The third is an active-low manual reset request. Any qualified fault pulls the reset output low. Once every fault has gone away, the output stays low for a fixed number of clock cycles before it releases.

All timing is counted in cycles of one free-running clock. The undervoltage flag and the manual reset input are asynchronous, so each passes through a two-flop synchronizer. Each is then qualified by a consecutive-cycle counter:
- An undervoltage level has to persist for an entry window before it counts as a fault.
- After the flag drops, a separate exit window must pass before the fault clears.
- A manual reset low level shorter than a minimum width is discarded.

After the block's own power-on reset, and again after every lockout episode, a startup interval runs before the undervoltage flag is trusted. Reset is held low for the whole of that interval.

The lockout flag does not go through any qualification. It forces the output low in the same cycle it is raised, and it restarts the startup interval.

Top module: `reset_release_seq`

## Requirements
- R1: While `arst_n` is low, `sys_rst_n` is 0.
- R2: After `arst_n` is released with `lockout` low, `uv_async` low and `mr_async_n` high, `sys_rst_n` first reads 1 after the (STARTUP_CYC+TIMEOUT_CYC)-th rising clock edge that follows the release.
- R3: While `lockout` is 1, `sys_rst_n` is 0 in the same cycle, whatever the other inputs are. After `lockout` falls, `sys_rst_n` first reads 1 after the (STARTUP_CYC+TIMEOUT_CYC)-th rising edge, because the startup interval restarts. A lockout pulse during startup restarts that interval from zero.
- R4: When `mr_async_n` is held low for MR_MIN_CYC or more cycles, `sys_rst_n` reads 0 after the (MR_MIN_CYC+2)-th rising edge following the fall, and stays 0 while the input remains low.
- R5: A low pulse on `mr_async_n` lasting fewer than MR_MIN_CYC cycles is ignored: `sys_rst_n` stays 1.
- R6: When `uv_async` is high (1 = undervoltage) for UV_ENTER_CYC or more cycles, `sys_rst_n` reads 0 after the (UV_ENTER_CYC+2)-th rising edge. A high pulse shorter than UV_ENTER_CYC cycles is ignored.
- R7: After a qualified undervoltage, once `uv_async` falls, `sys_rst_n` first reads 1 after the (UV_EXIT_CYC+TIMEOUT_CYC+2)-th rising edge.
- R8: After a qualified manual reset ends, `sys_rst_n` first reads 1 after the (TIMEOUT_CYC+3)-th rising edge. The release needs TIMEOUT_CYC consecutive fault-free cycles.
- R9: A qualified fault that arrives while the release timeout is running restarts the timeout from zero. The release is then timed from the end of the new fault, as in R8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock that counts every interval |
| arst_n | input | 1 | Asynchronous active-low power-on reset of the block |
| uv_async | input | 1 | Asynchronous undervoltage flag, 1 = undervoltage |
| lockout | input | 1 | Synchronous lockout flag, 1 = supply below minimum |
| mr_async_n | input | 1 | Asynchronous active-low manual reset request |
| sys_rst_n | output | 1 | Active-low system reset |

## Verification
The bench builds the block with TIMEOUT_CYC=40, STARTUP_CYC=12, UV_ENTER_CYC=3, UV_EXIT_CYC=6 and MR_MIN_CYC=4. With these values every interval completes within a few dozen cycles, so exact edge counts can be checked for each latency and release. Random pulse widths reach up to twice each qualification window. That places both sides of the accept/reject boundary for manual and undervoltage pulses within a short run. The short timeout also lets a second fault land in the middle of a running release.

// File: rtl/reset_release_seq.sv
module reset_release_seq #(
  parameter int unsigned TIMEOUT_CYC  = 200000,
  parameter int unsigned STARTUP_CYC  = 300,
  parameter int unsigned UV_ENTER_CYC = 17,
  parameter int unsigned UV_EXIT_CYC  = 35,
  parameter int unsigned MR_MIN_CYC   = 1
) (
  input  logic clk,
  input  logic arst_n,
  input  logic uv_async,
  input  logic lockout,
  input  logic mr_async_n,
  output logic sys_rst_n
);
  localparam int unsigned UV_MAX = (UV_ENTER_CYC > UV_EXIT_CYC) ? UV_ENTER_CYC : UV_EXIT_CYC;
  localparam int unsigned TW = $clog2(TIMEOUT_CYC + 1);
  localparam int unsigned SW = $clog2(STARTUP_CYC + 1);
  localparam int unsigned UW = $clog2(UV_MAX + 1);
  localparam int unsigned MW = $clog2(MR_MIN_CYC + 1);

  logic [1:0] uv_sync, mr_sync;
  logic uv_s, mr_s;

  always_ff @(posedge clk or negedge arst_n)
    if (!arst_n) begin
      uv_sync <= 2'b00;
      mr_sync <= 2'b11;
    end else begin
      uv_sync <= {uv_sync[0], uv_async};
      mr_sync <= {mr_sync[0], mr_async_n};
    end

  assign uv_s = uv_sync[1];
  assign mr_s = mr_sync[1];

  logic [SW-1:0] st_cnt;
  logic st_done;
  assign st_done = (st_cnt == SW'(STARTUP_CYC));

  always_ff @(posedge clk or negedge arst_n)
    if (!arst_n)       st_cnt <= '0;
    else if (lockout)  st_cnt <= '0;
    else if (!st_done) st_cnt <= st_cnt + 1'b1;

  logic uv_q;
  logic [UW-1:0] uv_cnt, uv_lim;
  assign uv_lim = uv_q ? UW'(UV_EXIT_CYC - 1) : UW'(UV_ENTER_CYC - 1);

  always_ff @(posedge clk or negedge arst_n)
    if (!arst_n) begin
      uv_q   <= 1'b0;
      uv_cnt <= '0;
    end else if (uv_s == uv_q) begin
      uv_cnt <= '0;
    end else if (uv_cnt == uv_lim) begin
      uv_q   <= uv_s;
      uv_cnt <= '0;
    end else begin
      uv_cnt <= uv_cnt + 1'b1;
    end

  logic [MW-1:0] mr_cnt;
  logic mr_act;
  assign mr_act = (mr_cnt == MW'(MR_MIN_CYC));

  always_ff @(posedge clk or negedge arst_n)
    if (!arst_n)      mr_cnt <= '0;
    else if (mr_s)    mr_cnt <= '0;
    else if (!mr_act) mr_cnt <= mr_cnt + 1'b1;

  logic fault;
  assign fault = lockout | ~st_done | uv_q | mr_act;

  logic [TW-1:0] to_cnt;
  logic rel;

  always_ff @(posedge clk or negedge arst_n)
    if (!arst_n) begin
      to_cnt <= '0;
      rel    <= 1'b0;
    end else if (fault) begin
      to_cnt <= '0;
      rel    <= 1'b0;
    end else if (!rel) begin
      if (to_cnt == TW'(TIMEOUT_CYC - 1)) rel <= 1'b1;
      else                                to_cnt <= to_cnt + 1'b1;
    end

  assign sys_rst_n = rel & ~fault;
endmodule

// File: rtl/reset_release_seq_chk.sv
module reset_release_seq_chk #(
  parameter int unsigned TIMEOUT_CYC  = 200000,
  parameter int unsigned UV_ENTER_CYC = 17,
  parameter int unsigned MR_MIN_CYC   = 1
) (
  input logic clk,
  input logic arst_n,
  input logic uv_async,
  input logic lockout,
  input logic mr_async_n,
  input logic sys_rst_n
);
  int unsigned lk_quiet, mr_low, uv_high;

  always_ff @(posedge clk or negedge arst_n)
    if (!arst_n) begin
      lk_quiet <= 0;
      mr_low   <= 0;
      uv_high  <= 0;
    end else begin
      lk_quiet <= lockout ? 0 : ((lk_quiet < TIMEOUT_CYC) ? lk_quiet + 1 : lk_quiet);
      mr_low   <= mr_async_n ? 0 : ((mr_low < MR_MIN_CYC + 2) ? mr_low + 1 : mr_low);
      uv_high  <= !uv_async ? 0 : ((uv_high < UV_ENTER_CYC + 2) ? uv_high + 1 : uv_high);
    end

  a_r1_low_in_reset: assert property (@(posedge clk) !arst_n |-> !sys_rst_n);

  a_r3_lockout_forces_low: assert property (@(posedge clk) disable iff (!arst_n)
    lockout |-> !sys_rst_n);

  a_r4_mr_held_asserts: assert property (@(posedge clk) disable iff (!arst_n)
    (mr_low == MR_MIN_CYC + 2) |-> !sys_rst_n);

  a_r6_uv_held_asserts: assert property (@(posedge clk) disable iff (!arst_n)
    (uv_high == UV_ENTER_CYC + 2) |-> !sys_rst_n);

  a_r8_release_needs_quiet: assert property (@(posedge clk) disable iff (!arst_n)
    $rose(sys_rst_n) |-> (lk_quiet >= TIMEOUT_CYC));
endmodule

bind reset_release_seq reset_release_seq_chk #(
  .TIMEOUT_CYC(TIMEOUT_CYC), .UV_ENTER_CYC(UV_ENTER_CYC), .MR_MIN_CYC(MR_MIN_CYC)
) i_chk (
  .clk(clk), .arst_n(arst_n), .uv_async(uv_async), .lockout(lockout),
  .mr_async_n(mr_async_n), .sys_rst_n(sys_rst_n)
);

// File: tb/test_reset_release_seq.sv
module test_reset_release_seq;
  localparam int T = 40, S = 12, UE = 3, UX = 6, MM = 4;

  logic clk = 0, arst_n = 0, uv = 0, lk = 0, mr_n = 1;
  logic sys_rst_n;
  int checks = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  reset_release_seq #(.TIMEOUT_CYC(T), .STARTUP_CYC(S), .UV_ENTER_CYC(UE),
                      .UV_EXIT_CYC(UX), .MR_MIN_CYC(MM)) i_reset_release_seq (
    .clk(clk), .arst_n(arst_n), .uv_async(uv), .lockout(lk),
    .mr_async_n(mr_n), .sys_rst_n(sys_rst_n));

  function automatic bit pulse_accepted(int len, int lim);
    return len >= lim;
  endfunction

  function automatic int release_edges(int kind);
    case (kind)
      0: return S + T;
      1: return T + 3;
      default: return UX + T + 2;
    endcase
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic count_until(input logic lvl, output int n);
    n = 0;
    do begin
      @(posedge clk); #1; n++;
    end while (sys_rst_n !== lvl && n < 5000);
  endtask

  task automatic report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual 0 expected 1");
      report();
    end
  end

  initial begin
    int n;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    check(sys_rst_n === 1'b0, "R1", sys_rst_n, 0);

    // R2 startup then timeout
    arst_n = 1;
    count_until(1, n);
    check(n == release_edges(0), "R2", n, release_edges(0));

    // R4 / R8 qualified manual reset
    @(negedge clk); mr_n = 0;
    count_until(0, n);
    check(n == MM + 2, "R4", n, MM + 2);
    @(negedge clk); mr_n = 1;
    count_until(1, n);
    check(n == release_edges(1), "R8", n, release_edges(1));

    // R5 short manual pulse
    @(negedge clk); mr_n = 0;
    repeat (MM - 1) @(negedge clk);
    mr_n = 1;
    n = 0;
    repeat (MM + 8) begin @(posedge clk); #1; if (sys_rst_n !== 1'b1) n++; end
    check(n == 0, "R5", n, 0);

    // R6 / R7 undervoltage entry and exit
    @(negedge clk); uv = 1;
    count_until(0, n);
    check(n == UE + 2, "R6", n, UE + 2);
    @(negedge clk); uv = 0;
    count_until(1, n);
    check(n == release_edges(2), "R7", n, release_edges(2));

    // R6 short undervoltage pulse
    @(negedge clk); uv = 1;
    repeat (UE - 1) @(negedge clk);
    uv = 0;
    n = 0;
    repeat (UE + 8) begin @(posedge clk); #1; if (sys_rst_n !== 1'b1) n++; end
    check(n == 0, "R6 short pulse", n, 0);

    // R3 lockout forces low, other inputs irrelevant
    @(negedge clk); lk = 1; #1;
    check(sys_rst_n === 1'b0, "R3 immediate", sys_rst_n, 0);
    n = 0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk); mr_n = i[0]; uv = i[1]; #1;
      if (sys_rst_n !== 1'b0) n++;
    end
    check(n == 0, "R3 held", n, 0);
    @(negedge clk); mr_n = 1; uv = 0;
    repeat (4) @(negedge clk);
    lk = 0;
    count_until(1, n);
    check(n == release_edges(0), "R3 release", n, release_edges(0));

    // R9 fault during running timeout
    @(negedge clk); mr_n = 0;
    repeat (MM + 2) @(negedge clk);
    mr_n = 1;
    repeat (T / 2) @(negedge clk);
    check(sys_rst_n === 1'b0, "R9 mid timeout", sys_rst_n, 0);
    mr_n = 0;
    repeat (MM + 1) @(negedge clk);
    mr_n = 1;
    count_until(1, n);
    check(n == release_edges(1), "R9", n, release_edges(1));

    // R3 lockout pulse during startup restarts it
    @(negedge clk); arst_n = 0;
    @(negedge clk); arst_n = 1;
    repeat (S / 2) @(negedge clk);
    lk = 1;
    @(negedge clk); lk = 0;
    count_until(1, n);
    check(n == release_edges(0), "R3 startup restart", n, release_edges(0));

    // R5 / R6 random pulse widths around the qualification limits
    for (int it = 0; it < 24; it++) begin
      bit is_mr;
      int lim, len, low_seen;
      is_mr = $urandom % 2;
      lim = is_mr ? MM : UE;
      len = 1 + ($urandom % (2 * lim));
      low_seen = 0;
      @(negedge clk);
      for (int c = 0; c < len + 8; c++) begin
        if (is_mr) mr_n = (c >= len);
        else       uv   = (c < len);
        @(posedge clk); #1;
        if (sys_rst_n !== 1'b1) low_seen = 1;
        @(negedge clk);
      end
      check(low_seen == int'(pulse_accepted(len, lim)), is_mr ? "R5 random" : "R6 random",
            low_seen, int'(pulse_accepted(len, lim)));
      if (sys_rst_n !== 1'b1) count_until(1, n);
    end

    done = 1;
    report();
  end
endmodule